// File: doc/BRIEF.md
# Coalescing Miss Tracking File

This block holds a small set of miss-tracking entries for a non-blocking data cache. Each time a load misses the first-level cache, the requester presents the load address and an 8-bit instruction sequence tag. The block answers in the same cycle. It either folds the load into an entry that already tracks the same line, or it opens a new entry, or it turns the load away. A turned-away load learns how many cycles remain before the soonest entry completes.

Each entry holds the aligned line address, the sequence tag of the load that opened it, a reference count, and a countdown of the cycles left until its fill completes. A load that depends on a pending store is flagged by a conflict input that carries the wait for that store, and the new entry's countdown starts from that wait instead of the miss latency. Requesters drop their reference through a release port. An entry whose count reaches zero is invalidated. It is then held out of the free pool for one cycle before it can be reused.

Sequence tags live in a circular window of 256 values. They are ordered by their signed 8-bit distance from a retirement base that the pipeline drives.

Top module: `coalescing_mshr_file`

## Requirements
- R1: After reset no entry is valid. The first request allocates entry 0 and reports a delay equal to the miss latency `MISS_LAT` (default 12).
- R2: Request addresses are compared only after their low `LINE_OFF` bits (default 6) are cleared. Two addresses in the same line therefore select the same entry.
- R3: A request merges into a valid entry only when all of these hold: the lines match, the entry's tag distance (tag minus `base_i`, read as signed 8-bit) is less than or equal to the request's distance, and the entry's reference count is below its maximum of 15. The lowest such index wins. The response gives the entry's remaining cycles.
- R4: When any entry qualifies for a merge, the request merges and no entry is allocated. A merge adds one to the count, unless a release hits the same entry in that cycle, in which case the count is unchanged.
- R5: Without a merge, a new entry is allocated at the lowest free index. A request with `req_oldest_i` high needs at least one free entry; any other request needs at least two. The reported delay is `MISS_LAT`, or max(1, `req_conflict_wait_i`) when `req_conflict_i` is high. A newly allocated entry starts with a count of 1.
- R6: A request that can neither merge nor allocate is rejected. Its delay is the negated minimum remaining cycles over all valid entries, or -1 if no entry is valid.
- R7: A release lowers the count of a valid entry. When the count goes from 1 to 0, the entry is invalid from the next cycle. A release aimed at an invalid entry has no effect.
- R8: An entry freed by a release cannot be allocated in the cycle that follows. It can be allocated from the cycle after that.
- R9: The remaining cycles of an entry fall by one each clock and hold at zero. A request one cycle after allocation sees the allocation delay minus one.
- R10: `resp_kind_o` is encoded as 0 = none, 1 = merged, 2 = allocated, 3 = rejected. It reads 0 whenever `req_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_i | input | 8 | Retirement base of the sequence tag window |
| req_valid_i | input | 1 | Miss request present |
| req_addr_i | input | ADDR_W | Load address |
| req_tag_i | input | 8 | Sequence tag of the load |
| req_oldest_i | input | 1 | Load is the oldest in flight and may take the last free entry |
| req_conflict_i | input | 1 | Load waits on a pending store to the same line |
| req_conflict_wait_i | input | LAT_W | Cycles until that store finishes |
| rel_valid_i | input | 1 | Release one reference |
| rel_idx_i | input | IDX_W | Entry to release |
| resp_kind_o | output | 2 | Outcome code (R10) |
| resp_idx_o | output | IDX_W | Entry merged into or allocated, else 0 |
| resp_delay_o | output | LAT_W+1 | Signed delay; negative on rejection |

## Verification
The bench goes after several corner cases. One is a request whose tag is older than a live entry for the same line; a design that ignored ordering would merge it instead of opening a second entry. Another is the reserve rule with exactly one free entry, where a loose check would hand the last slot to a younger load. A third is the cycle just after a release, where a design without the hold would reuse the slot at once. The bench also checks the rejection delay against the soonest countdown, merge-plus-release in the same cycle, releases aimed at empty slots, and the reference count at saturation. All of these are checked under a long random stream with a wrapping retirement base.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int unsigned SEQ_W = 8;
  typedef logic [SEQ_W-1:0] seq_t;

  typedef enum logic [1:0] {
    RESP_NONE   = 2'd0,
    RESP_MERGE  = 2'd1,
    RESP_ALLOC  = 2'd2,
    RESP_REJECT = 2'd3
  } resp_e;

  // signed distance of a tag from the retirement base
  function automatic logic signed [SEQ_W-1:0] seq_dist(seq_t tag, seq_t base);
    seq_dist = tag - base;
  endfunction
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LAT_W  = 8,
  parameter int unsigned REF_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_line_i,
  input  seq_t              alloc_tag_i,
  input  logic [LAT_W-1:0]  alloc_time_i,
  input  logic              merge_i,
  input  logic              release_i,
  output logic              valid_o,
  output logic              parked_o,
  output logic [ADDR_W-1:0] line_o,
  output seq_t              tag_o,
  output logic [LAT_W-1:0]  remain_o,
  output logic [REF_W-1:0]  ref_o
);
  logic              valid_q, parked_q;
  logic [ADDR_W-1:0] line_q;
  seq_t              tag_q;
  logic [LAT_W-1:0]  remain_q;
  logic [REF_W-1:0]  ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      parked_q <= 1'b0;
      line_q   <= '0;
      tag_q    <= '0;
      remain_q <= '0;
      ref_q    <= '0;
    end else begin
      parked_q <= 1'b0;
      if (alloc_i) begin
        valid_q  <= 1'b1;
        line_q   <= alloc_line_i;
        tag_q    <= alloc_tag_i;
        remain_q <= alloc_time_i - 1'b1;  // reported delay counts this cycle
        ref_q    <= REF_W'(1);
      end else begin
        if (remain_q != '0) remain_q <= remain_q - 1'b1;
        if (valid_q) begin
          if (merge_i && !release_i) begin
            ref_q <= ref_q + 1'b1;
          end else if (release_i && !merge_i) begin
            if (ref_q == REF_W'(1)) begin
              valid_q  <= 1'b0;
              ref_q    <= '0;
              parked_q <= 1'b1;
            end else begin
              ref_q <= ref_q - 1'b1;
            end
          end
        end
      end
    end
  end

  assign valid_o  = valid_q;
  assign parked_o = parked_q;
  assign line_o   = line_q;
  assign tag_o    = tag_q;
  assign remain_o = remain_q;
  assign ref_o    = ref_q;

  a_r7_ref_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> ref_q != '0);
  a_r8_park_on_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_q) |-> parked_q);
  a_r8_park_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parked_q |=> !parked_q);
  a_r9_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_i && remain_q != '0) |=> remain_q == $past(remain_q) - 1'b1);
endmodule

// File: rtl/mshr_match.sv
module mshr_match
  import mshr_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REF_W  = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              valid_i [N],
  input  logic [ADDR_W-1:0] line_i  [N],
  input  seq_t              tag_i   [N],
  input  logic [REF_W-1:0]  ref_i   [N],
  input  logic [ADDR_W-1:0] req_line_i,
  input  seq_t              req_tag_i,
  input  seq_t              base_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o
);
  logic [N-1:0] cand;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign cand[g] = valid_i[g] && (line_i[g] == req_line_i)
                  && (seq_dist(tag_i[g], base_i) <= seq_dist(req_tag_i, base_i))
                  && !(&ref_i[g]);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |cand;
endmodule

// File: rtl/mshr_pool.sv
module mshr_pool #(
  parameter int unsigned N     = 4,
  parameter int unsigned LAT_W = 8,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic             valid_i  [N],
  input  logic             parked_i [N],
  input  logic [LAT_W-1:0] remain_i [N],
  output logic [CNT_W-1:0] free_cnt_o,
  output logic [IDX_W-1:0] free_idx_o,
  output logic             any_valid_o,
  output logic [LAT_W-1:0] min_remain_o
);
  always_comb begin
    free_cnt_o   = '0;
    free_idx_o   = '0;
    any_valid_o  = 1'b0;
    min_remain_o = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i] && !parked_i[i]) begin
        free_cnt_o = free_cnt_o + CNT_W'(1);
        free_idx_o = IDX_W'(i);
      end
    end
    for (int i = 0; i < N; i++) begin
      if (valid_i[i]) begin
        any_valid_o = 1'b1;
        if (remain_i[i] < min_remain_o) min_remain_o = remain_i[i];
      end
    end
  end
endmodule

// File: rtl/coalescing_mshr_file.sv
module coalescing_mshr_file
  import mshr_pkg::*;
#(
  parameter int unsigned N_ENTRY  = 4,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LINE_OFF = 6,
  parameter int unsigned LAT_W    = 8,
  parameter int unsigned MISS_LAT = 12,
  parameter int unsigned REF_W    = 4,
  localparam int unsigned IDX_W   = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
  localparam int unsigned CNT_W   = $clog2(N_ENTRY + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         base_i,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [7:0]         req_tag_i,
  input  logic               req_oldest_i,
  input  logic               req_conflict_i,
  input  logic [LAT_W-1:0]   req_conflict_wait_i,
  input  logic               rel_valid_i,
  input  logic [IDX_W-1:0]   rel_idx_i,
  output logic [1:0]         resp_kind_o,
  output logic [IDX_W-1:0]   resp_idx_o,
  output logic signed [LAT_W:0] resp_delay_o
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << LINE_OFF) - 64'd1);

  logic              valid_w  [N_ENTRY];
  logic              parked_w [N_ENTRY];
  logic [ADDR_W-1:0] line_w   [N_ENTRY];
  seq_t              tag_w    [N_ENTRY];
  logic [LAT_W-1:0]  remain_w [N_ENTRY];
  logic [REF_W-1:0]  ref_w    [N_ENTRY];

  logic [ADDR_W-1:0] req_line;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx, free_idx;
  logic [CNT_W-1:0]  free_cnt;
  logic              any_valid;
  logic [LAT_W-1:0]  min_remain, alloc_time;
  logic              do_merge, do_alloc, do_reject;
  resp_e             kind;

  assign req_line = req_addr_i & ~OFF_MASK;

  mshr_match #(.N(N_ENTRY), .ADDR_W(ADDR_W), .REF_W(REF_W), .IDX_W(IDX_W)) match_i (
    .valid_i(valid_w), .line_i(line_w), .tag_i(tag_w), .ref_i(ref_w),
    .req_line_i(req_line), .req_tag_i(req_tag_i), .base_i(base_i),
    .hit_o(hit), .hit_idx_o(hit_idx)
  );

  mshr_pool #(.N(N_ENTRY), .LAT_W(LAT_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) pool_i (
    .valid_i(valid_w), .parked_i(parked_w), .remain_i(remain_w),
    .free_cnt_o(free_cnt), .free_idx_o(free_idx),
    .any_valid_o(any_valid), .min_remain_o(min_remain)
  );

  assign alloc_time = req_conflict_i
                    ? ((req_conflict_wait_i == '0) ? LAT_W'(1) : req_conflict_wait_i)
                    : LAT_W'(MISS_LAT);

  // merge wins; last free slot only for the oldest load
  assign do_merge  = req_valid_i && hit;
  assign do_alloc  = req_valid_i && !hit &&
                     ((free_cnt >= CNT_W'(2)) || (req_oldest_i && free_cnt != '0));
  assign do_reject = req_valid_i && !do_merge && !do_alloc;

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
    mshr_entry #(.ADDR_W(ADDR_W), .LAT_W(LAT_W), .REF_W(REF_W)) ent_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .alloc_i(do_alloc && free_idx == IDX_W'(g)),
      .alloc_line_i(req_line), .alloc_tag_i(req_tag_i), .alloc_time_i(alloc_time),
      .merge_i(do_merge && hit_idx == IDX_W'(g)),
      .release_i(rel_valid_i && rel_idx_i == IDX_W'(g)),
      .valid_o(valid_w[g]), .parked_o(parked_w[g]), .line_o(line_w[g]),
      .tag_o(tag_w[g]), .remain_o(remain_w[g]), .ref_o(ref_w[g])
    );
  end

  always_comb begin
    kind         = RESP_NONE;
    resp_idx_o   = '0;
    resp_delay_o = '0;
    if (do_merge) begin
      kind         = RESP_MERGE;
      resp_idx_o   = hit_idx;
      resp_delay_o = $signed({1'b0, remain_w[hit_idx]});
    end else if (do_alloc) begin
      kind         = RESP_ALLOC;
      resp_idx_o   = free_idx;
      resp_delay_o = $signed({1'b0, alloc_time});
    end else if (do_reject) begin
      kind         = RESP_REJECT;
      resp_delay_o = any_valid ? -$signed({1'b0, min_remain}) : '1;
    end
  end
  assign resp_kind_o = kind;

  a_r5_alloc_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_kind_o == RESP_ALLOC) |=> valid_w[$past(resp_idx_o)] && ref_w[$past(resp_idx_o)] == REF_W'(1));
  a_r8_no_parked_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_kind_o == RESP_ALLOC) |-> !parked_w[resp_idx_o] && !valid_w[resp_idx_o]);
  a_r4_merge_adds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_kind_o == RESP_MERGE && !(rel_valid_i && rel_idx_i == resp_idx_o))
      |=> ref_w[$past(resp_idx_o)] == $past(ref_w[resp_idx_o]) + 1'b1);
  a_r6_reject_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_kind_o == RESP_REJECT) |-> resp_delay_o <= 0);
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> resp_kind_o == RESP_NONE);
endmodule

// File: tb/coalescing_mshr_file_tb_top.sv
module coalescing_mshr_file_tb_top;
  localparam int N = 4, ADDR_W = 32, OFF = 6, LAT_W = 8, LAT = 12, IDX_W = 2;
  localparam int NO = 9999;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]        base = '0, tag = '0;
  logic              req_v = 0, old = 0, cf = 0, rv = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [LAT_W-1:0]  cw = '0;
  logic [IDX_W-1:0]  ri = '0;
  logic [1:0]        kind_o;
  logic [IDX_W-1:0]  idx_o;
  logic signed [LAT_W:0] delay_o;

  coalescing_mshr_file #(.N_ENTRY(N), .ADDR_W(ADDR_W), .LINE_OFF(OFF), .LAT_W(LAT_W),
                         .MISS_LAT(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base), .req_valid_i(req_v), .req_addr_i(addr),
    .req_tag_i(tag), .req_oldest_i(old), .req_conflict_i(cf), .req_conflict_wait_i(cw),
    .rel_valid_i(rv), .rel_idx_i(ri), .resp_kind_o(kind_o), .resp_idx_o(idx_o),
    .resp_delay_o(delay_o)
  );

  int checks = 0, errors = 0;
  bit mv[N], mp[N];
  logic [ADDR_W-1:0] ml[N];
  logic [7:0] mt[N];
  int mr[N], mref[N];

  function automatic int sd(logic [7:0] t, logic [7:0] b);
    logic [7:0] d;
    d = t - b;
    return int'($signed(d));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] a, logic [7:0] t, bit o, bit c, logic [7:0] w,
                      bit r, int rix, string lbl, int ek, int ed);
    int hit, fc, fi, at, minr, k, ix, d;
    bit anyv, newp[N];
    logic [31:0] line;
    @(negedge clk);
    req_v = v; addr = a; tag = t; old = o; cf = c; cw = w; rv = r; ri = IDX_W'(rix);
    #5;
    line = a & ~32'h3f;
    hit = -1; fc = 0; fi = -1; minr = 1 << 30; anyv = 0;
    for (int i = 0; i < N; i++) begin
      if (hit < 0 && mv[i] && ml[i] == line && sd(mt[i], base) <= sd(t, base) && mref[i] < 15) hit = i;
      if (!mv[i] && !mp[i]) begin fc++; if (fi < 0) fi = i; end
      if (mv[i]) begin anyv = 1; if (mr[i] < minr) minr = mr[i]; end
    end
    at = c ? ((w == 0) ? 1 : int'(w)) : LAT;
    ix = 0; d = 0;
    if (!v) k = 0;
    else if (hit >= 0) begin k = 1; ix = hit; d = mr[hit]; end
    else if (fc >= 2 || (fc >= 1 && o)) begin k = 2; ix = fi; d = at; end
    else begin k = 3; d = anyv ? -minr : -1; end
    chk(int'(kind_o) == k, {lbl, " kind"}, int'(kind_o), k);
    if (k == 1 || k == 2) chk(int'(idx_o) == ix, {lbl, " idx"}, int'(idx_o), ix);
    if (k != 0) chk(int'(delay_o) == d, {lbl, " delay"}, int'(delay_o), d);
    if (ek >= 0) chk(int'(kind_o) == ek, {lbl, " directed kind"}, int'(kind_o), ek);
    if (ed != NO) chk(int'(delay_o) == ed, {lbl, " directed delay"}, int'(delay_o), ed);
    // model next state
    for (int i = 0; i < N; i++) begin
      newp[i] = 0;
      if (mr[i] > 0) mr[i]--;
    end
    if (r && mv[rix] && !(k == 1 && hit == rix)) begin
      if (mref[rix] == 1) begin mv[rix] = 0; mref[rix] = 0; newp[rix] = 1; end
      else mref[rix]--;
    end
    if (k == 1 && !(r && rix == hit)) mref[hit]++;
    if (k == 2) begin mv[fi] = 1; ml[fi] = line; mt[fi] = t; mr[fi] = at - 1; mref[fi] = 1; end
    for (int i = 0; i < N; i++) mp[i] = newp[i];
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; mp[i] = 0; mr[i] = 0; mref[i] = 0; ml[i] = '0; mt[i] = '0; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R10 idle and reset state
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10", 0, NO);
    step(1, 32'h1000, 8'd10, 0, 0, 0, 0, 0, "R1", 2, LAT);
    step(1, 32'h1004, 8'd12, 0, 0, 0, 0, 0, "R2 R9", 1, LAT - 1);
    step(1, 32'h1000, 8'd5, 0, 0, 0, 0, 0, "R3", 2, LAT);
    step(1, 32'h2000, 8'd20, 0, 0, 0, 0, 0, "R5", 2, LAT);
    step(1, 32'h3000, 8'd21, 0, 0, 0, 0, 0, "R5 R6", 3, -8);
    step(1, 32'h3000, 8'd21, 1, 1, 0, 0, 0, "R5", 2, 1);
    step(0, 0, 0, 0, 0, 0, 1, 2, "R7 R10", 0, NO);
    step(1, 32'h4000, 8'd30, 1, 0, 0, 0, 0, "R8", 3, 0);
    step(1, 32'h4000, 8'd30, 1, 0, 0, 0, 0, "R8", 2, LAT);
    step(1, 32'h1020, 8'd40, 0, 0, 0, 0, 0, "R4 R9", 1, 3);
    step(0, 0, 0, 0, 0, 0, 1, 0, "R7", 0, NO);
    step(1, 32'h1000, 8'd41, 0, 0, 0, 0, 0, "R7 R9", 1, 1);
    // random stream
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      logic [7:0] t;
      if ($urandom_range(0, 19) == 0) base = base + 8'($urandom_range(0, 8));
      a = 32'h0010_0000 | (32'($urandom_range(0, 5)) << OFF) | 32'($urandom_range(0, 63));
      t = base + 8'($urandom_range(0, 60)) - 8'd10;
      step($urandom_range(0, 9) < 7, a, t, $urandom_range(0, 9) < 3,
           $urandom_range(0, 4) == 0, 8'($urandom_range(0, 20)),
           $urandom_range(0, 9) < 4, $urandom_range(0, N - 1),
           "R2/R3/R4/R5/R6/R7/R8/R9 random", -1, NO);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial void'($urandom(32'h5eed));
endmodule